// File: doc/BRIEF.md
# Security-Filtered Interrupt Pending Bank

This block keeps the pending state of a set of shared interrupts as a bank of memory-mapped 32-bit words. Every interrupt also carries a two-bit group assignment held in a separate group configuration area of the same bank. Each bus transaction carries a one-bit security tag: secure or non-secure. The block uses that tag, and not any notion of who issued the request, to decide which interrupts the transaction may observe or mark pending.

A secure transaction sees and may set the pending bit of every interrupt. A non-secure transaction sees only the interrupts assigned to the non-secure group; every other bit reads as zero and ignores writes. Writes only ever set pending bits. Clearing is handled elsewhere. A per-interrupt hardware pulse input sets pending state as well. Reads complete with a fixed latency of one cycle. The group configuration can be changed and read back only by secure transactions.

Top module: `irq_pend_guard`

## Requirements
- R1: After reset every pending bit is 0, every interrupt is in group code 2'b00, and `rsp_valid` is low.
- R2: A read accepted in cycle N raises `rsp_valid` in cycle N+1 with data taken from the state before the edge that accepted it. `rsp_valid` is low in every other cycle. Reads of addresses 6 and 7 return zero.
- R3: A secure read of a pending word returns the pending bit of every interrupt it covers, whatever its group.
- R4: A non-secure read of a pending word returns the pending bit only for interrupts in group 2'b01. All other bits are zero.
- R5: A write to a pending word sets each bit written as 1 that the transaction may touch. A bit written as 0 has no effect, and no bus access ever clears a pending bit.
- R6: A non-secure write to a pending word leaves unchanged the bits of interrupts whose group code is not 2'b01.
- R7: A `hw_set` bit high in cycle N makes that interrupt's pending bit 1 from cycle N+1 on.
- R8: A `hw_set` pulse and a bus write setting the same interrupt in the same cycle leave the bit set, including when the bus write is filtered out.
- R9: Group word g, at address 2+g, holds interrupts 16g to 16g+15, with interrupt i in bits [2(i%16)+1 : 2(i%16)]. The codes are 2'b00 group 0 (secure), 2'b01 non-secure group 1, 2'b10 secure group 1, and 2'b11, which is handled as secure group 1.
- R10: Only secure writes change group words. Non-secure writes to them are ignored, and non-secure reads of them return zero.
- R11: Pending word w, at address w (w = 0 or 1), covers interrupts 32w to 32w+31, with interrupt i in bit i%32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security tag of the transaction, 1 = secure |
| req_addr | input | ADDR_W (3) | Word address |
| req_wdata | input | 32 | Write data |
| hw_set | input | NUM_IRQ (64) | Per-interrupt hardware set pulse |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Filtered read data |

## Verification
Read data is due exactly one cycle after the edge that accepts the read. The bench drives each request on a falling edge and samples the response on the next falling edge, after the single response register has loaded. Write and hardware-set effects land on the accepting edge, so the bench checks them through a later read, which arrives one cycle after that. A read issued in the same cycle as a hardware pulse must return the value from before the pulse, which confirms that the response samples state ahead of the update. A sweep over every interrupt and every group code, with both tags, compares each response with a value the bench computes from its own copy of the group and pending state.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned GRP_BITS  = 2;
    localparam int unsigned IRQ_PER_GRP_WORD = DATA_W / GRP_BITS;

    // group assignment codes
    typedef enum logic [1:0] {
        GRP_G0    = 2'b00,
        GRP_NS_G1 = 2'b01,
        GRP_S_G1  = 2'b10,
        GRP_RSVD  = 2'b11
    } grp_e;

    // which part of the bank an address falls in
    typedef enum logic [1:0] {
        SPACE_PEND = 2'b00,
        SPACE_GRP  = 2'b01,
        SPACE_NONE = 2'b10
    } space_e;

    // only the non-secure group is reachable with a non-secure tag
    function automatic logic ns_may_touch(input logic [1:0] code);
        return grp_e'(code) == GRP_NS_G1;
    endfunction

    function automatic int unsigned idx_width(input int unsigned words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction

endpackage

// File: rtl/irq_grp_cfg.sv
module irq_grp_cfg
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    localparam int unsigned GRP_WORDS = NUM_IRQ / IRQ_PER_GRP_WORD,
    localparam int unsigned GI_W = idx_width(GRP_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [GI_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [GRP_BITS*NUM_IRQ-1:0] grp_flat
);

    for (genvar g = 0; g < GRP_WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == GI_W'(g))) begin
                word_q <= wr_data;
            end
        end

        assign grp_flat[g*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/irq_pend_store.sv
module irq_pend_store
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    localparam int unsigned PEND_WORDS = NUM_IRQ / DATA_W,
    localparam int unsigned PI_W = idx_width(PEND_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IRQ-1:0]  hw_set,
    input  logic                sw_en,
    input  logic [PI_W-1:0]     sw_idx,
    input  logic [DATA_W-1:0]   sw_mask,
    output logic [NUM_IRQ-1:0]  pend
);

    for (genvar w = 0; w < PEND_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic [DATA_W-1:0] sw_bits;

        assign sw_bits = (sw_en && (sw_idx == PI_W'(w))) ? sw_mask : '0;

        // set-only storage: hardware and software sources merge by OR
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else begin
                word_q <= word_q | hw_set[w*DATA_W +: DATA_W] | sw_bits;
            end
        end

        assign pend[w*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/irq_pend_view.sv
module irq_pend_view
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic                        secure,
    input  logic [GRP_BITS*NUM_IRQ-1:0] grp_flat,
    output logic [NUM_IRQ-1:0]          access
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        assign access[i] = secure | ns_may_touch(grp_flat[i*GRP_BITS +: GRP_BITS]);
    end

endmodule

// File: rtl/irq_pend_rsp.sv
module irq_pend_rsp
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    localparam int unsigned PEND_WORDS = NUM_IRQ / DATA_W,
    localparam int unsigned GRP_WORDS  = NUM_IRQ / IRQ_PER_GRP_WORD,
    localparam int unsigned PI_W = idx_width(PEND_WORDS),
    localparam int unsigned GI_W = idx_width(GRP_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  space_e                      space,
    input  logic                        secure,
    input  logic [PI_W-1:0]             pend_idx,
    input  logic [GI_W-1:0]             grp_idx,
    input  logic [NUM_IRQ-1:0]          pend,
    input  logic [NUM_IRQ-1:0]          access,
    input  logic [GRP_BITS*NUM_IRQ-1:0] grp_flat,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata
);

    logic [DATA_W-1:0] pend_word;
    logic [DATA_W-1:0] grp_word;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        pend_word = '0;
        for (int w = 0; w < int'(PEND_WORDS); w++) begin
            if (pend_idx == PI_W'(w)) begin
                pend_word = pend[w*DATA_W +: DATA_W] & access[w*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        grp_word = '0;
        for (int g = 0; g < int'(GRP_WORDS); g++) begin
            if (grp_idx == GI_W'(g)) begin
                grp_word = grp_flat[g*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        unique case (space)
            SPACE_PEND: rd_word = pend_word;
            SPACE_GRP:  rd_word = secure ? grp_word : '0;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? rd_word : '0;
        end
    end

endmodule

// File: rtl/irq_pend_guard.sv
module irq_pend_guard
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned ADDR_W  = 3,
    localparam int unsigned PEND_WORDS = NUM_IRQ / DATA_W,
    localparam int unsigned GRP_WORDS  = NUM_IRQ / IRQ_PER_GRP_WORD,
    localparam int unsigned PI_W = idx_width(PEND_WORDS),
    localparam int unsigned GI_W = idx_width(GRP_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_secure,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [31:0]         req_wdata,
    input  logic [NUM_IRQ-1:0]  hw_set,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata
);

    space_e                       space;
    logic [PI_W-1:0]              pend_idx;
    logic [GI_W-1:0]              grp_idx;
    logic [ADDR_W-1:0]            grp_off;
    logic [NUM_IRQ-1:0]           access;
    logic [NUM_IRQ-1:0]           pend_q;
    logic [GRP_BITS*NUM_IRQ-1:0]  grp_q;
    logic [DATA_W-1:0]            wr_access;
    logic                         pend_wr;
    logic                         grp_wr;
    logic                         rd_en;

    // address decode: pending words first, group words after them
    assign grp_off  = req_addr - ADDR_W'(PEND_WORDS);
    assign pend_idx = PI_W'(req_addr);
    assign grp_idx  = GI_W'(grp_off);

    always_comb begin
        if (req_addr < ADDR_W'(PEND_WORDS)) begin
            space = SPACE_PEND;
        end else if (req_addr < ADDR_W'(PEND_WORDS + GRP_WORDS)) begin
            space = SPACE_GRP;
        end else begin
            space = SPACE_NONE;
        end
    end

    assign rd_en   = req_valid && !req_write;
    assign pend_wr = req_valid && req_write && (space == SPACE_PEND);
    assign grp_wr  = req_valid && req_write && req_secure && (space == SPACE_GRP);

    irq_pend_view #(.NUM_IRQ(NUM_IRQ)) u_view (
        .secure   (req_secure),
        .grp_flat (grp_q),
        .access   (access)
    );

    always_comb begin
        wr_access = '0;
        for (int w = 0; w < int'(PEND_WORDS); w++) begin
            if (pend_idx == PI_W'(w)) begin
                wr_access = access[w*DATA_W +: DATA_W];
            end
        end
    end

    irq_grp_cfg #(.NUM_IRQ(NUM_IRQ)) u_grp (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (grp_wr),
        .wr_idx   (grp_idx),
        .wr_data  (req_wdata),
        .grp_flat (grp_q)
    );

    irq_pend_store #(.NUM_IRQ(NUM_IRQ)) u_store (
        .clk     (clk),
        .rst     (rst),
        .hw_set  (hw_set),
        .sw_en   (pend_wr),
        .sw_idx  (pend_idx),
        .sw_mask (req_wdata & wr_access),
        .pend    (pend_q)
    );

    irq_pend_rsp #(.NUM_IRQ(NUM_IRQ)) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .space     (space),
        .secure    (req_secure),
        .pend_idx  (pend_idx),
        .grp_idx   (grp_idx),
        .pend      (pend_q),
        .access    (access),
        .grp_flat  (grp_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/irq_pend_guard_chk.sv
module irq_pend_guard_chk
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned ADDR_W  = 3,
    localparam int unsigned PEND_WORDS = NUM_IRQ / DATA_W
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_write,
    input logic                        req_secure,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [NUM_IRQ-1:0]          hw_set,
    input logic                        rsp_valid,
    input logic [31:0]                 rsp_rdata,
    input logic [NUM_IRQ-1:0]          pend,
    input logic [GRP_BITS*NUM_IRQ-1:0] grp_flat
);

    logic [NUM_IRQ-1:0] ns_vis;
    logic [31:0]        ns_allow;

    always_comb begin
        for (int i = 0; i < int'(NUM_IRQ); i++) begin
            ns_vis[i] = (grp_flat[i*2 +: 2] == 2'b01);
        end
    end

    always_comb begin
        ns_allow = '0;
        for (int w = 0; w < int'(PEND_WORDS); w++) begin
            if (req_addr == ADDR_W'(w)) begin
                ns_allow = ns_vis[w*32 +: 32];
            end
        end
    end

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R4
    ns_read_filtered_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_secure) |=> ((rsp_rdata & ~$past(ns_allow)) == 32'h0));

    // R5
    pend_never_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (pend & $past(pend)) == $past(pend));

    // R6
    ns_write_guarded_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_secure)
        |=> (((pend ^ $past(pend)) & ~($past(ns_vis) | $past(hw_set))) == '0));

    // R7
    hw_set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((pend & $past(hw_set)) == $past(hw_set)));

    // R10
    grp_secure_only_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_secure) |=> $stable(grp_flat));

endmodule

bind irq_pend_guard irq_pend_guard_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .hw_set     (hw_set),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .pend       (pend_q),
    .grp_flat   (grp_q)
);

// File: tb/irq_pend_guard_bench.sv
`timescale 1ns/1ps
module irq_pend_guard_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [63:0] hw_set = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    bit       pend_m [64];
    bit [1:0] grp_m  [64];

    always #4 clk = ~clk;

    irq_pend_guard u_irq_pend_guard (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_secure (req_secure),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .hw_set     (hw_set),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int a, input bit sec);
        logic [31:0] r = '0;
        if (a < 2) begin
            for (int b = 0; b < 32; b++) begin
                r[b] = pend_m[a*32+b] & (sec || grp_m[a*32+b] == 2'b01);
            end
        end else if (a < 6 && sec) begin
            for (int k = 0; k < 16; k++) r[2*k +: 2] = grp_m[(a-2)*16+k];
        end
        return r;
    endfunction

    task automatic model_write(input int a, input bit sec, input logic [31:0] d);
        if (a < 2) begin
            for (int b = 0; b < 32; b++)
                if (d[b] && (sec || grp_m[a*32+b] == 2'b01)) pend_m[a*32+b] = 1'b1;
        end else if (a < 6 && sec) begin
            for (int k = 0; k < 16; k++) grp_m[(a-2)*16+k] = d[2*k +: 2];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 64; i++) begin
            pend_m[i] = 1'b0;
            grp_m[i]  = 2'b00;
        end
    endtask

    task automatic bus_write(input int a, input bit sec, input logic [31:0] d,
                             input logic [63:0] hw);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_secure = sec;
        req_addr = 3'(a); req_wdata = d; hw_set = hw;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; hw_set = '0;
        model_write(a, sec, d);
        for (int i = 0; i < 64; i++) if (hw[i]) pend_m[i] = 1'b1;
    endtask

    task automatic bus_read(input int a, input bit sec, input logic [63:0] hw,
                            input string req);
        logic [31:0] exp;
        exp = exp_word(a, sec);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_secure = sec;
        req_addr = 3'(a); hw_set = hw;
        @(negedge clk);
        req_valid = 1'b0; hw_set = '0;
        for (int i = 0; i < 64; i++) if (hw[i]) pend_m[i] = 1'b1;
        check({31'b0, rsp_valid}, 32'd1, {req, " rsp_valid"});
        check(rsp_rdata, exp, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state observed through the bus
        @(negedge clk);
        check({31'b0, rsp_valid}, 32'd0, "R1 rsp_valid idle");
        for (int a = 0; a < 6; a++) bus_read(a, 1'b1, '0, "R1 reset contents");

        // R9 and R10: group layout and secure-only access
        for (int g = 0; g < 4; g++) begin
            logic [31:0] d = '0;
            for (int k = 0; k < 16; k++) d[2*k +: 2] = 2'((g*16 + k) % 4);
            bus_write(2 + g, 1'b1, d, '0);
        end
        for (int g = 0; g < 4; g++) bus_read(2 + g, 1'b1, '0, "R9 group readback");
        bus_write(3, 1'b0, 32'hFFFF_FFFF, '0);
        bus_read(3, 1'b1, '0, "R10 ns group write ignored");
        bus_read(4, 1'b0, '0, "R10 ns group read zero");

        // R6 / R4 / R3 with mixed groups
        bus_write(0, 1'b0, 32'hFFFF_FFFF, '0);
        bus_write(1, 1'b0, 32'hFFFF_FFFF, '0);
        for (int a = 0; a < 2; a++) begin
            bus_read(a, 1'b0, '0, "R4 ns view mixed");
            bus_read(a, 1'b1, '0, "R6 secure view after ns write");
        end
        // R5: zero writes do nothing, ones set
        bus_write(0, 1'b1, 32'h0, '0);
        bus_read(0, 1'b1, '0, "R5 zero write no effect");
        bus_write(1, 1'b1, 32'hA5A5_0F0F, '0);
        bus_read(1, 1'b1, '0, "R5 secure set pattern");
        bus_read(1, 1'b0, '0, "R4 ns view pattern");
        // R2: unmapped addresses
        bus_read(6, 1'b1, '0, "R2 unmapped 6");
        bus_read(7, 1'b0, '0, "R2 unmapped 7");
        @(negedge clk);
        check({31'b0, rsp_valid}, 32'd0, "R2 no response when idle");

        // R7 and R2 ordering: read in same cycle as hw pulse sees old state
        do_reset();
        bus_read(0, 1'b1, 64'h0000_0000_0000_0100, "R2 read precedes same-cycle hw_set");
        bus_read(0, 1'b1, '0, "R7 hw_set landed");
        bus_write(0, 1'b1, 32'h0, 64'h8000_0000_0000_0000);
        bus_read(1, 1'b1, '0, "R7 hw_set top irq");

        // R8: hw pulse and bus set on the same interrupt, filtered and unfiltered
        do_reset();
        bus_write(0, 1'b1, 32'h0000_0020, 64'h0000_0000_0000_0020);
        bus_write(0, 1'b0, 32'h0000_0040, 64'h0000_0000_0000_0040);
        bus_read(0, 1'b1, '0, "R8 same-cycle set");

        // R11 sweep: every interrupt under every group code and both tags
        for (int irq = 0; irq < 64; irq++) begin
            for (int g = 0; g < 4; g++) begin
                logic [31:0] gd = '0;
                do_reset();
                gd[2*(irq%16) +: 2] = 2'(g);
                bus_write(2 + irq/16, 1'b1, gd, '0);
                bus_write(irq/32, 1'b0, 32'(1) << (irq%32), '0);
                bus_read(irq/32, 1'b0, '0, "R11 sweep ns view");
                bus_read(irq/32, 1'b1, '0, "R11 sweep secure view");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule